// File: doc/BRIEF.md
# Synchronous Smart-Card Bit Receiver

This block collects the bits a synchronous smart card sends on its data line, including the answer-to-reset, and delivers them as bytes to firmware. The card clock and the data line come in from the card pins. Both pass through a synchronizer into the system clock domain. A data bit is taken on each rising edge of the card clock while the block is in receive mode. Bits are assembled least significant bit first into a byte register, and a one-cycle strobe marks each completed byte.

Firmware loads a length before each block of bits. A running count of the accepted bits is compared against that length. When the count reaches the length, a sticky interrupt flag is raised and further bits are refused until the next load. Changing the transmit/receive mode bit in either direction restarts the position within the byte. The card reset pin is a registered, non-inverted copy of a control bit. A typical answer-to-reset read follows these steps:

1. Raise the reset bit.
2. Wait for the length interrupt.
3. Clear the interrupt.
4. Drop the reset bit.
5. Toggle the mode bit to realign the byte position.
6. Load the next length.

Top module: `cbr_sync_rx`

## Requirements
- R1: After reset, `card_rst`, `irq`, `byte_vld`, `bit_pos` and `rx_bits` are all 0, and the length limit is 0.
- R2: The data line is sampled only at a rising edge of `card_clk`. A change of `card_io` while `card_clk` is high, or at its falling edge, does not alter the bit taken.
- R3: Bits are placed least significant bit first. After every 8 accepted bits, `rx_byte` holds the assembled byte and `byte_vld` is high for exactly one system clock cycle.
- R4: While `mode_tx` is 1 (transmit), card clock edges are ignored: `rx_bits`, `bit_pos` and `byte_vld` do not change.
- R5: Any change of `mode_tx`, from 0 to 1 or from 1 to 0, returns `bit_pos` to 0 on the next cycle and discards the partial byte. It does not change `rx_bits`.
- R6: A `len_load` pulse clears `rx_bits` to 0 and sets the limit to `len_value`. Each accepted bit increments `rx_bits` by one. When `rx_bits` reaches the limit, `irq` is set.
- R7: While `rx_bits` equals the limit, bits are refused: `rx_bits` stays the same and no byte is produced. This holds until the next `len_load`, and it holds from reset before any load.
- R8: `irq` stays high until an `irq_clr` pulse. If a new set and a clear fall in the same cycle, the set wins and `irq` stays 1.
- R9: `card_rst` equals `rst_ctl` as it was one system clock cycle earlier, with no inversion.
- R10: Loading a length of 0 sets `irq` on the next cycle, and no bits are accepted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_clk | input | 1 | Card clock, asynchronous to `clk` |
| card_io | input | 1 | Card data line |
| mode_tx | input | 1 | 1 = transmit (bits ignored), 0 = receive |
| rst_ctl | input | 1 | Firmware card-reset bit |
| len_load | input | 1 | One-cycle pulse that reloads the length limit |
| len_value | input | LEN_W | Number of bits to receive after the load |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| card_rst | output | 1 | Card reset pin |
| rx_byte | output | DATA_W | Last completed byte |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| bit_pos | output | $clog2(DATA_W) | Bit position within the current byte |
| rx_bits | output | LEN_W | Bits accepted since the last load |
| irq | output | 1 | Sticky length-reached flag |

## Verification
The bench moves `card_io` while the card clock is high. A receiver that samples at the wrong edge, or keeps sampling while the clock is high, would then build a different byte than the scoreboard expects.

It sends extra bits after the limit is reached and also before the first load. A receiver without the halt would produce bytes that nobody expected and would count past the limit.

It toggles the mode bit in the middle of a byte and sends bits in transmit mode. If the alignment reset or the mode gating were missing, the next byte would come out shifted or too early.

Finally, a zero-length load is issued in the same cycle as an interrupt clear. If clear took priority over set, or if a zero length were not handled, the interrupt would be lost.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  // one synchronized observation of the card pins
  typedef struct packed {
    logic rise;   // rising edge of the card clock seen this cycle
    logic data;   // data line, aligned with the clock path
  } line_evt_t;
endpackage

// File: rtl/cbr_line_sync.sv
module cbr_line_sync
  import cbr_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      card_clk,
  input  logic      card_io,
  output line_evt_t evt
);
  logic [STAGES-1:0] clk_sr;
  logic [STAGES-1:0] io_sr;
  logic              clk_prev;

  // identical depth on both paths keeps data aligned with the clock edge
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sr   <= '0;
      io_sr    <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], card_clk};
      io_sr    <= {io_sr[STAGES-2:0], card_io};
      clk_prev <= clk_sr[STAGES-1];
    end
  end

  always_comb begin
    evt.rise = clk_sr[STAGES-1] & ~clk_prev;
    evt.data = io_sr[STAGES-1];
  end
endmodule

// File: rtl/cbr_shifter.sv
module cbr_shifter #(
  parameter int DATA_W = 8,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              realign,
  input  logic              accept,
  input  logic              bit_in,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_vld,
  output logic [POS_W-1:0]  pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shreg_nxt;

  always_comb shreg_nxt = {bit_in, shreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      byte_out <= '0;
      byte_vld <= 1'b0;
      pos      <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (realign) begin
        shreg <= '0;
        pos   <= '0;
      end else if (accept) begin
        shreg <= shreg_nxt;
        if (pos == LAST) begin
          pos      <= '0;
          byte_out <= shreg_nxt;
          byte_vld <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cbr_len_ctr.sv
module cbr_len_ctr #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] value,
  input  logic             bit_acc,
  input  logic             irq_clr,
  output logic [LEN_W-1:0] count,
  output logic             halted,
  output logic             irq
);
  logic [LEN_W-1:0] limit;
  logic             irq_set;

  always_comb begin
    halted  = (count == limit);
    irq_set = (load && value == '0) ||
              (!load && bit_acc && (count + 1'b1) == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      limit <= '0;
      irq   <= 1'b0;
    end else begin
      if (load) begin
        count <= '0;
        limit <= value;
      end else if (bit_acc) begin
        count <= count + 1'b1;
      end
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/cbr_sync_rx.sv
module cbr_sync_rx
  import cbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              card_clk,
  input  logic              card_io,
  input  logic              mode_tx,
  input  logic              rst_ctl,
  input  logic              len_load,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              irq_clr,
  output logic              card_rst,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_vld,
  output logic [POS_W-1:0]  bit_pos,
  output logic [LEN_W-1:0]  rx_bits,
  output logic              irq
);
  line_evt_t evt;
  logic      mode_prev;
  logic      mode_chg;
  logic      halted;
  logic      accept;

  cbr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .card_clk(card_clk), .card_io(card_io), .evt(evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_prev <= mode_tx;
      card_rst  <= 1'b0;
    end else begin
      mode_prev <= mode_tx;
      card_rst  <= rst_ctl;
    end
  end

  always_comb begin
    mode_chg = mode_tx ^ mode_prev;
    accept   = evt.rise & ~mode_tx & ~mode_chg & ~halted & ~len_load;
  end

  cbr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .realign(mode_chg), .accept(accept),
    .bit_in(evt.data), .byte_out(rx_byte), .byte_vld(byte_vld), .pos(bit_pos)
  );

  cbr_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .load(len_load), .value(len_value),
    .bit_acc(accept), .irq_clr(irq_clr), .count(rx_bits),
    .halted(halted), .irq(irq)
  );
endmodule

// File: rtl/cbr_sync_rx_chk.sv
module cbr_sync_rx_chk #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 10,
  localparam int POS_W = $clog2(DATA_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_tx,
  input logic             rst_ctl,
  input logic             len_load,
  input logic             irq_clr,
  input logic             card_rst,
  input logic             byte_vld,
  input logic [POS_W-1:0] bit_pos,
  input logic [LEN_W-1:0] rx_bits,
  input logic             irq
);
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld); // R3

  AST_TX_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_tx)) |-> !byte_vld); // R4

  AST_MODE_REALIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_tx != $past(mode_tx)) |=> bit_pos == '0); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(len_load) && rx_bits != $past(rx_bits))
      |-> rx_bits == LEN_W'($past(rx_bits) + 1'b1)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq); // R8

  AST_RST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> card_rst == $past(rst_ctl)); // R9
endmodule

bind cbr_sync_rx cbr_sync_rx_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .mode_tx(mode_tx), .rst_ctl(rst_ctl),
  .len_load(len_load), .irq_clr(irq_clr), .card_rst(card_rst),
  .byte_vld(byte_vld), .bit_pos(bit_pos), .rx_bits(rx_bits), .irq(irq)
);

// File: tb/sim_cbr_sync_rx.sv
`timescale 1ns/1ps
module sim_cbr_sync_rx;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              card_clk = 1'b0;
  logic              card_io = 1'b0;
  logic              mode_tx = 1'b0;
  logic              rst_ctl = 1'b0;
  logic              len_load = 1'b0;
  logic [LEN_W-1:0]  len_value = '0;
  logic              irq_clr = 1'b0;
  logic              card_rst;
  logic [DATA_W-1:0] rx_byte;
  logic              byte_vld;
  logic [2:0]        bit_pos;
  logic [LEN_W-1:0]  rx_bits;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] exp_q[$];

  always #5 clk = ~clk;

  cbr_sync_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .card_clk(card_clk), .card_io(card_io),
    .mode_tx(mode_tx), .rst_ctl(rst_ctl), .len_load(len_load),
    .len_value(len_value), .irq_clr(irq_clr), .card_rst(card_rst),
    .rx_byte(rx_byte), .byte_vld(byte_vld), .bit_pos(bit_pos),
    .rx_bits(rx_bits), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one card clock period; with flip the line moves while the clock is high
  task automatic send_bit(input logic b, input logic flip);
    @(negedge clk);
    card_io = b;
    idle(4);
    card_clk = 1'b1;
    idle(2);
    if (flip) card_io = ~b;
    idle(3);
    card_clk = 1'b0;
    idle(4);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic flip, input logic expect_out);
    if (expect_out) exp_q.push_back(v);
    for (int i = 0; i < 8; i++) send_bit(v[i], flip);
  endtask

  task automatic load_len(input int n);
    @(negedge clk);
    len_value = LEN_W'(n);
    len_load  = 1'b1;
    @(negedge clk);
    len_load  = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && byte_vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected byte actual=%0d expected=none", rx_byte);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_byte != e) begin
          fails++;
          $display("FAIL R3 byte actual=%0h expected=%0h", rx_byte, e);
        end
      end
    end
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 card_rst", card_rst, 0);
    chk("R1 irq", irq, 0);
    chk("R1 byte_vld", byte_vld, 0);
    chk("R1 bit_pos", bit_pos, 0);
    chk("R1 rx_bits", rx_bits, 0);

    // R9 card reset pin follows control bit
    @(negedge clk) rst_ctl = 1'b1;
    @(negedge clk) chk("R9 card_rst high", card_rst, 1);
    @(negedge clk) rst_ctl = 1'b0;
    @(negedge clk) chk("R9 card_rst low", card_rst, 0);

    // R7 nothing accepted before the first load (limit 0)
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    chk("R7 no bits before load", rx_bits, 0);
    chk("R7 no position before load", bit_pos, 0);

    // R6 R3 R2 two bytes, second with the line moving while clock is high
    load_len(16);
    chk("R6 reload clears count", rx_bits, 0);
    send_byte(8'hA5, 1'b0, 1'b1);
    chk("R6 count after byte", rx_bits, 8);
    chk("R6 no irq mid block", irq, 0);
    send_byte(8'h3C, 1'b1, 1'b1);
    chk("R6 count at limit", rx_bits, 16);
    chk("R6 irq at limit", irq, 1);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    // R7 halted at limit
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
    chk("R7 count held", rx_bits, 16);
    chk("R7 position held", bit_pos, 0);

    // R8 sticky then cleared
    idle(20);
    chk("R8 irq sticky", irq, 1);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk("R8 irq cleared", irq, 0);

    // R5 mode toggle mid byte, R4 transmit mode ignores edges
    load_len(40);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    chk("R5 position before toggle", bit_pos, 3);
    @(negedge clk) mode_tx = 1'b1;
    idle(2);
    chk("R5 position realigned", bit_pos, 0);
    chk("R5 count kept", rx_bits, 3);
    send_byte(8'hFF, 1'b0, 1'b0);
    chk("R4 tx count unchanged", rx_bits, 3);
    chk("R4 tx position unchanged", bit_pos, 0);
    @(negedge clk) mode_tx = 1'b0;
    idle(2);
    send_byte(8'h5A, 1'b0, 1'b1);
    chk("R5 aligned byte count", rx_bits, 11);
    chk("R3 aligned byte drained", exp_q.size(), 0);

    // R10 R8 zero length load with simultaneous clear: set wins
    @(negedge clk);
    len_value = '0;
    len_load  = 1'b1;
    irq_clr   = 1'b1;
    @(negedge clk);
    len_load  = 1'b0;
    irq_clr   = 1'b0;
    chk("R10 irq on zero load", irq, 1);
    chk("R8 set wins over clear", irq, 1);
    send_byte(8'h81, 1'b0, 1'b0);
    chk("R10 no bits accepted", rx_bits, 0);
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule